// File: doc/BRIEF.md
# Streaming ReLU and 2x2 Max-Pool Writer

This block sits at the output of a convolution engine. The engine emits one output value per cycle at most, together with its column, row and feature-map index. The block applies ReLU and 2x2 max pooling to each value as it arrives. There is no line buffer. The running maximum of each pooling cell lives in the destination feature-map memory, and the block updates it with one read, compare and write per value. The pooled map is therefore complete in the cycle after the last convolution value arrives.

A value at an even column and an even row opens a new pooling cell. For that value the block issues no read and compares the sample against zero, which performs ReLU. Every later value for the same cell reads the stored partial maximum and writes back the larger of the two. The memory has a registered read port with one cycle of latency, and a read that meets a write to the same address in the same cycle returns the old data. When two consecutive values target one cell, the block forwards the value it has just written instead of using the memory data.

Top module: `relu_maxpool_stream`

## Requirements
- R1: While reset is asserted, and afterwards in any cycle with no valid input before it, `wr_en` and `rd_en` are low.
- R2: A value at column x, row y of map m targets address m*(MAP_W/2)*(MAP_H/2) + (y>>1)*(MAP_W/2) + (x>>1).
- R3: A value whose x and y are both even (bit 0 of each is 0) issues no read. The next cycle writes max(value, 0) and ignores whatever the memory held at that address.
- R4: Any other valid value drives `rd_en` high with the target address in the same cycle. The next cycle writes the larger of the value and the stored partial maximum.
- R5: Each valid input produces exactly one write, exactly one cycle later. No write happens otherwise.
- R6: Every written value is non-negative. A cell whose four inputs are all negative holds 0.
- R7: When a value targets the cell written in the same cycle, the comparison uses the value being written, not the stale memory data.
- R8: After all four values of a cell have arrived, the cell holds max(0, v0, v1, v2, v3) in any arrival order in which the even/even value comes first.
- R9: Comparisons are signed 16-bit two's complement. 0x8000 is the smallest value and 0x7FFF the largest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Convolution value present this cycle |
| in_data | input | DATA_W | Signed convolution value |
| in_x | input | XW | Column of the value in its map |
| in_y | input | YW | Row of the value in its map |
| in_map | input | MW | Feature-map index |
| rd_en | output | 1 | Read request to the output memory |
| rd_addr | output | AW | Read address |
| rd_data | input | DATA_W | Read data, one cycle after the request |
| wr_en | output | 1 | Write strobe to the output memory |
| wr_addr | output | AW | Write address |
| wr_data | output | DATA_W | Updated partial maximum |

## Verification
The bench fills the memory with a large positive pattern before any cell opens. A design that reads on an even/even value, or trusts the stored word, leaves that pattern in place of the ReLU result.

Raster order makes the two values of each row pair arrive back to back. Tile order makes four same-cell values arrive in a row. A design without forwarding loses the maximum of one value in each such pair.

Windows made only of negative values, some equal to 0x8000, catch an unsigned compare, which would keep a negative word. They also catch a missing ReLU, which would store the window's maximum instead of 0.

Gaps in the valid stream catch writes that are not tied to exactly one input.

// File: rtl/relu_pool_pkg.sv
package relu_pool_pkg;
  // Source of the comparison reference for one incoming value
  typedef enum logic [1:0] {
    REF_ZERO = 2'd0,   // first value of a cell: compare with zero (ReLU)
    REF_MEM  = 2'd1,   // stored partial maximum from memory
    REF_FWD  = 2'd2    // value written in the previous cycle
  } ref_sel_e;
endpackage

// File: rtl/rp_addr_gen.sv
module rp_addr_gen #(
  parameter int MAP_W    = 8,
  parameter int MAP_H    = 6,
  parameter int NUM_MAPS = 3,
  parameter int XW       = 3,
  parameter int YW       = 3,
  parameter int MW       = 2,
  parameter int AW       = 6
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic [MW-1:0] map,
  output logic [AW-1:0] addr,
  output logic          first
);
  localparam int PW    = MAP_W / 2;
  localparam int PH    = MAP_H / 2;
  localparam int PLANE = PW * PH;

  logic [AW-1:0] col_p;
  logic [AW-1:0] row_p;
  logic [AW-1:0] map_p;

  always_comb begin
    col_p = AW'(x >> 1);
    row_p = AW'(y >> 1);
    map_p = AW'(map);
    addr  = map_p * AW'(PLANE) + row_p * AW'(PW) + col_p;
    first = ~x[0] & ~y[0];
  end
endmodule

// File: rtl/rp_fwd_unit.sv
module rp_fwd_unit
  import relu_pool_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_first,
  input  logic [AW-1:0]     cur_addr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ref_sel_e          sel,
  output logic [DATA_W-1:0] fwd_data
);
  logic              last_v, last_v_nx;
  logic [AW-1:0]     last_a, last_a_nx;
  logic [DATA_W-1:0] last_d, last_d_nx;
  logic              last_ld;

  always_comb begin
    last_v_nx = wr_en;
    last_ld   = wr_en;
    last_a_nx = wr_addr;
    last_d_nx = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_v <= 1'b0;
      last_a <= '0;
      last_d <= '0;
    end else begin
      last_v <= last_v_nx;
      if (last_ld) begin
        last_a <= last_a_nx;
        last_d <= last_d_nx;
      end
    end
  end

  always_comb begin
    if (cur_first)                           sel = REF_ZERO;
    else if (last_v && (last_a == cur_addr)) sel = REF_FWD;
    else                                     sel = REF_MEM;
    fwd_data = last_d;
  end

  // R7: forwarding selected only when the previous cycle wrote that same cell
  a_r7_fwd_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REF_FWD) |-> ($past(wr_en) && ($past(wr_addr) == cur_addr)));
endmodule

// File: rtl/rp_max_cmp.sv
module rp_max_cmp
  import relu_pool_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  ref_sel_e          sel,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [DATA_W-1:0] fwd_data,
  output logic [DATA_W-1:0] result
);
  logic signed [DATA_W-1:0] ref_v;
  logic signed [DATA_W-1:0] smp_v;

  always_comb begin
    unique case (sel)
      REF_ZERO: ref_v = '0;
      REF_FWD:  ref_v = $signed(fwd_data);
      default:  ref_v = $signed(mem_data);
    endcase
    smp_v  = $signed(sample);
    result = (smp_v > ref_v) ? sample : DATA_W'(ref_v);
  end

  // R9: output never falls below either operand in signed order
  always_comb begin
    a_r9_signed_max: assert ($signed(result) >= smp_v && $signed(result) >= ref_v);
  end
endmodule

// File: rtl/relu_maxpool_stream.sv
module relu_maxpool_stream
  import relu_pool_pkg::*;
#(
  parameter int  DATA_W   = 16,
  parameter int  MAP_W    = 8,
  parameter int  MAP_H    = 6,
  parameter int  NUM_MAPS = 3,
  localparam int XW       = (MAP_W > 1) ? $clog2(MAP_W) : 1,
  localparam int YW       = (MAP_H > 1) ? $clog2(MAP_H) : 1,
  localparam int MW       = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1,
  localparam int DEPTH    = NUM_MAPS * (MAP_W / 2) * (MAP_H / 2),
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [XW-1:0]     in_x,
  input  logic [YW-1:0]     in_y,
  input  logic [MW-1:0]     in_map,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  // Stage A: address and read issue
  logic [AW-1:0] addr_a;
  logic          first_a;

  rp_addr_gen #(
    .MAP_W(MAP_W), .MAP_H(MAP_H), .NUM_MAPS(NUM_MAPS),
    .XW(XW), .YW(YW), .MW(MW), .AW(AW)
  ) u_addr (
    .x(in_x), .y(in_y), .map(in_map), .addr(addr_a), .first(first_a)
  );

  assign rd_en   = in_valid & ~first_a;
  assign rd_addr = addr_a;

  // Stage B: compare and write
  logic              b_valid, b_valid_nx;
  logic              b_first, b_first_nx;
  logic [AW-1:0]     b_addr,  b_addr_nx;
  logic [DATA_W-1:0] b_data,  b_data_nx;
  logic              b_ld;

  always_comb begin
    b_valid_nx = in_valid;
    b_ld       = in_valid;
    b_first_nx = first_a;
    b_addr_nx  = addr_a;
    b_data_nx  = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_valid <= 1'b0;
      b_first <= 1'b0;
      b_addr  <= '0;
      b_data  <= '0;
    end else begin
      b_valid <= b_valid_nx;
      if (b_ld) begin
        b_first <= b_first_nx;
        b_addr  <= b_addr_nx;
        b_data  <= b_data_nx;
      end
    end
  end

  ref_sel_e          sel;
  logic [DATA_W-1:0] fwd_data;
  logic [DATA_W-1:0] cmp_out;

  rp_fwd_unit #(.DATA_W(DATA_W), .AW(AW)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .cur_first(b_first), .cur_addr(b_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel(sel), .fwd_data(fwd_data)
  );

  rp_max_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample(b_data), .sel(sel), .mem_data(rd_data),
    .fwd_data(fwd_data), .result(cmp_out)
  );

  assign wr_en   = b_valid;
  assign wr_addr = b_addr;
  assign wr_data = cmp_out;

  // R1: a read only ever accompanies a valid input
  a_r1_rd_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> in_valid);
  // R5: one write exactly one cycle after each valid input, none otherwise
  a_r5_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wr_en);
  a_r5_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en);
  // R4: write lands on the address that was read the cycle before
  a_r4_same_cell: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (wr_addr == $past(rd_addr)));
  // R6: ReLU output is never negative
  a_r6_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_data[DATA_W-1]);
  // R3: an even/even value opens a cell without reading
  a_r3_no_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_x[0] && !in_y[0]) |-> !rd_en);
endmodule

// File: tb/relu_maxpool_stream_tb.sv
module relu_maxpool_stream_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int MW_ = 8;
  localparam int MH_ = 6;
  localparam int NM_ = 3;
  localparam int PW_ = MW_ / 2;
  localparam int PH_ = MH_ / 2;
  localparam int DEPTH = NM_ * PW_ * PH_;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic [2:0]    in_x;
  logic [2:0]    in_y;
  logic [1:0]    in_map;
  logic          rd_en;
  logic [5:0]    rd_addr;
  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [5:0]    wr_addr;
  logic [DW-1:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  relu_maxpool_stream u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_x(in_x), .in_y(in_y), .in_map(in_map),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Output memory: registered read, old data on same-cycle collision
  logic [DW-1:0] mem [DEPTH];
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  int model [DEPTH];
  int raw [NM_][MH_][MW_];
  bit exp_wv = 0;
  int exp_wa = 0;
  int exp_wd = 0;
  int prev_a = -1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sx(input logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic step(input bit v, input int x, input int y, input int m,
                      input logic [DW-1:0] d);
    int a;
    bit first;
    int refv;
    int res;
    string rq;
    @(negedge clk);
    // outputs caused by the previous cycle's input
    check(wr_en == exp_wv, "R5", "wr_en", wr_en, exp_wv);
    if (exp_wv) begin
      check(wr_addr == exp_wa[5:0], "R2", "wr_addr", wr_addr, exp_wa);
      rq = (exp_wd >= 0 && prev_a == exp_wa) ? "R7" : "R4";
      check(sx(wr_data) == exp_wd, rq, "wr_data", sx(wr_data), exp_wd);
    end
    in_valid = v;
    in_x     = 3'(x);
    in_y     = 3'(y);
    in_map   = 2'(m);
    in_data  = d;
    #1;
    a     = m * PW_ * PH_ + (y / 2) * PW_ + (x / 2);
    first = (x % 2 == 0) && (y % 2 == 0);
    check(rd_en == (v && !first), first ? "R3" : "R4", "rd_en", rd_en, v && !first);
    if (v && !first) check(rd_addr == a[5:0], "R2", "rd_addr", rd_addr, a);
    // expected write next cycle
    prev_a = exp_wv ? exp_wa : -1;
    exp_wv = v;
    if (v) begin
      refv = first ? 0 : model[a];
      res  = (sx(d) > refv) ? sx(d) : refv;
      model[a] = res;
      raw[m][y][x] = sx(d);
      exp_wa = a;
      exp_wd = res;
    end
  endtask

  task automatic idle();
    step(1'b0, 0, 0, 0, '0);
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom_range(0, 65535));
  endfunction

  task automatic final_pool_check(input int m);
    for (int py = 0; py < PH_; py++) begin
      for (int px = 0; px < PW_; px++) begin
        int e = 0;
        int a = m * PW_ * PH_ + py * PW_ + px;
        for (int dy = 0; dy < 2; dy++)
          for (int dx = 0; dx < 2; dx++)
            if (raw[m][2*py+dy][2*px+dx] > e) e = raw[m][2*py+dy][2*px+dx];
        check(sx(mem[a]) == e, "R8", "pooled cell", sx(mem[a]), e);
      end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h7A5A;
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; in_x = '0; in_y = '0; in_map = '0;
    repeat (3) @(posedge clk);
    #1;
    check(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
    check(rd_en == 1'b0, "R1", "rd_en in reset", rd_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    idle();

    // Map 0: raster order, random data (R2 R4 R7 R8)
    for (int y = 0; y < MH_; y++)
      for (int x = 0; x < MW_; x++)
        step(1'b1, x, y, 0, rnd());
    idle();
    idle();
    final_pool_check(0);

    // Map 1: tile order, negative windows and extremes (R6 R7 R9)
    for (int py = 0; py < PH_; py++)
      for (int px = 0; px < PW_; px++)
        for (int k = 0; k < 4; k++) begin
          logic [DW-1:0] d;
          if (px == 0)                   d = 16'h8000 + DW'(k);   // all negative
          else if (px == 1 && k == 2)    d = 16'h7FFF;
          else if (px == 1)              d = 16'h8000;
          else if (px == 2 && k == 0)    d = 16'hFFFF;            // -1 first
          else                           d = rnd();
          step(1'b1, 2*px + (k % 2), 2*py + (k / 2), 1, d);
        end
    idle();
    idle();
    final_pool_check(1);

    // Map 2: raster order with gaps in the valid stream (R5 R8)
    for (int y = 0; y < MH_; y++)
      for (int x = 0; x < MW_; x++) begin
        if ($urandom_range(0, 2) == 0) idle();
        step(1'b1, x, y, 2, rnd());
      end
    idle();
    idle();
    final_pool_check(2);
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end
endmodule